// File: doc/BRIEF.md
# Data Channel Address and Count Engine

This block holds the per-transfer bookkeeping a peripheral needs for direct memory transfers over a data channel. It keeps a memory address counter, a transfer-length counter and a transfer word that captures the direction and the channel address at the start of each channel sequence. Every sequence advances both counters by one. The transfer length is held as a negative count that climbs toward zero. The move from all ones to zero raises a one-cycle notice to the peripheral.

A mode bit, latched when the host issues its reset command, picks where the channel address comes from. It is either the internal address counter or an address supplied by the peripheral on its own data lines. The host can preset either counter with its own write strobe, and a preset overrides an increment in the same cycle. Bus serialization happens elsewhere. This block only presents the parallel transfer word.

Top module: `dchan_addr_engine`

## Requirements
- R1: A synchronous active-high reset clears the address counter, the count register, the transfer word, the zero notice and the address-source mode bit.
- R2: Each cycle with `seq_go` high and no address write adds one to the 15-bit address counter. It wraps from 0x7FFF to 0x0000 with no flag of any kind.
- R3: Each cycle with `seq_go` high and no count write adds one to the 16-bit count register.
- R4: `cnt_zero_pulse` is high for exactly one cycle. That is the cycle after a sequence that takes the count from 0xFFFF to 0x0000. At all other times it is low.
- R5: On `seq_go` the transfer word captures the sequence direction in bit 15 and the channel address in bits 14:0. When the internal counter is the source, the captured address is its value before the increment.
- R6: With the mode bit at 0 the captured address is the internal address counter. With the mode bit at 1 it is `dev_addr`.
- R7: The mode bit takes `cfg_ext_en` only in a cycle with `cfg_load` high, and holds its value otherwise. A sequence in the same cycle as `cfg_load` uses the old value.
- R8: `addr_wr` loads `addr_wdata` into the address counter, and this load wins over an increment in the same cycle.
- R9: `cnt_wr` loads `cnt_wdata` into the count register. It wins over an increment in the same cycle, and that cycle raises no zero notice even if the count was 0xFFFF.
- R10: With `seq_go`, `addr_wr` and `cnt_wr` all low, the address, the count and the transfer word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Host reset-command strobe that latches the mode bit |
| cfg_ext_en | input | 1 | Mode value: 1 selects the peripheral-supplied address |
| addr_wr | input | 1 | Address counter write strobe |
| addr_wdata | input | 15 | Address preset value |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count preset value (two's complement of word count) |
| seq_go | input | 1 | One data channel sequence takes place this cycle |
| seq_dir | input | 1 | Direction of the sequence |
| dev_addr | input | 15 | Address supplied by the peripheral |
| addr_q | output | 15 | Address counter |
| cnt_q | output | 16 | Count register |
| xfer_q | output | 16 | Transfer word: bit 15 direction, bits 14:0 address |
| cnt_zero_pulse | output | 1 | One-cycle notice that the count has reached zero |
| ext_en_q | output | 1 | Current address-source mode bit |

## Verification
A wrong counter value shows on `addr_q` or `cnt_q` one clock after the sequence that caused it, and in the next transfer word one sequence later. A fault in the zero detection shows as a missing, doubled or extra `cnt_zero_pulse` in the cycle after a sequence at 0xFFFF. The bench therefore presets the count just below zero and walks across that edge. A wrong mode bit or source selection shows in bits 14:0 of the next captured transfer word. The cases where a load and an increment collide are driven on purpose, because there the fault is visible only in that single cycle.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam int unsigned DC_ADDR_W = 15;
  localparam int unsigned DC_CNT_W  = 16;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } addr_src_e;
endpackage

// File: rtl/dchan_counter.sv
module dchan_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/dchan_xfer_reg.sv
module dchan_xfer_reg
  import dchan_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          dir,
  input  addr_src_e     src,
  input  logic [AW-1:0] int_addr,
  input  logic [AW-1:0] ext_addr,
  output logic [AW:0]   xfer
);
  logic [AW-1:0] chan_addr;

  always_comb begin
    unique case (src)
      SRC_EXTERNAL: chan_addr = ext_addr;
      default:      chan_addr = int_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          xfer <= '0;
    else if (capture) xfer <= {dir, chan_addr};
  end
endmodule

// File: rtl/dchan_zero_pulse.sv
module dchan_zero_pulse #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] cnt,
  output logic         pulse
);
  logic at_top;
  assign at_top = &cnt;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= inc && !ld && at_top;
  end
endmodule

// File: rtl/dchan_addr_engine.sv
module dchan_addr_engine
  import dchan_pkg::*;
#(
  parameter int unsigned ADDR_W = DC_ADDR_W,
  parameter int unsigned CNT_W  = DC_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              cfg_ext_en,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              seq_go,
  input  logic              seq_dir,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W:0]   xfer_q,
  output logic              cnt_zero_pulse,
  output logic              ext_en_q
);
  localparam int unsigned XFER_W = ADDR_W + 1;

  addr_src_e   src_sel;
  logic [XFER_W-1:0] xfer_w;

  // Address-source mode bit, latched by the host reset command
  always_ff @(posedge clk) begin
    if (rst)           ext_en_q <= 1'b0;
    else if (cfg_load) ext_en_q <= cfg_ext_en;
  end

  assign src_sel = ext_en_q ? SRC_EXTERNAL : SRC_INTERNAL;

  dchan_counter #(.W(ADDR_W)) u_addr_cnt (
    .clk    (clk),
    .rst    (rst),
    .ld     (addr_wr),
    .ld_val (addr_wdata),
    .inc    (seq_go),
    .q      (addr_q)
  );

  dchan_counter #(.W(CNT_W)) u_word_cnt (
    .clk    (clk),
    .rst    (rst),
    .ld     (cnt_wr),
    .ld_val (cnt_wdata),
    .inc    (seq_go),
    .q      (cnt_q)
  );

  dchan_zero_pulse #(.W(CNT_W)) u_zero (
    .clk   (clk),
    .rst   (rst),
    .inc   (seq_go),
    .ld    (cnt_wr),
    .cnt   (cnt_q),
    .pulse (cnt_zero_pulse)
  );

  dchan_xfer_reg #(.AW(ADDR_W)) u_xfer (
    .clk      (clk),
    .rst      (rst),
    .capture  (seq_go),
    .dir      (seq_dir),
    .src      (src_sel),
    .int_addr (addr_q),
    .ext_addr (dev_addr),
    .xfer     (xfer_w)
  );

  assign xfer_q = xfer_w;
endmodule

// File: rtl/dchan_addr_engine_chk.sv
module dchan_addr_engine_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic              cfg_ext_en,
  input logic              addr_wr,
  input logic [ADDR_W-1:0] addr_wdata,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic              seq_go,
  input logic              seq_dir,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [ADDR_W:0]   xfer_q,
  input logic              cnt_zero_pulse,
  input logic              ext_en_q
);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_go && !addr_wr) |=> (addr_q == $past(addr_q) + 1'b1));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_go && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  zero_pulse_val_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_zero_pulse |-> (cnt_q == '0));

  // R4
  zero_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_zero_pulse |=> !cnt_zero_pulse);

  // R6
  ext_src_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_go && ext_en_q) |=> (xfer_q[ADDR_W-1:0] == $past(dev_addr)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(ext_en_q));

  // R8
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (addr_q == $past(addr_wdata)));

  // R9
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)) && !cnt_zero_pulse);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seq_go && !addr_wr && !cnt_wr) |=>
      ($stable(addr_q) && $stable(cnt_q) && $stable(xfer_q)));
endmodule

bind dchan_addr_engine dchan_addr_engine_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/dchan_addr_engine_bench.sv
module dchan_addr_engine_bench;
  localparam int unsigned AW = 15;
  localparam int unsigned CW = 16;

  typedef struct packed {
    logic          cl;  // cfg_load
    logic          cv;  // cfg_ext_en
    logic          aw;  // addr_wr
    logic [AW-1:0] ad;
    logic          cw;  // cnt_wr
    logic [CW-1:0] cd;
    logic          sq;  // seq_go
    logic          dr;  // seq_dir
    logic [AW-1:0] dv;  // dev_addr
    logic [AW-1:0] ea;  // expected addr
    logic [CW-1:0] ec;  // expected count
    logic [AW:0]   ex;  // expected transfer word
    logic          ep;  // expected pulse
    logic          ee;  // expected mode bit
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0, 1'b1,15'h7FFE, 1'b1,16'hFFFE, 1'b0,1'b0,15'h0000, 15'h7FFE,16'hFFFE,16'h0000,1'b0,1'b0},
    '{1'b0,1'b0, 1'b0,15'h0000, 1'b0,16'h0000, 1'b1,1'b1,15'h1234, 15'h7FFF,16'hFFFF,16'hFFFE,1'b0,1'b0},
    '{1'b0,1'b0, 1'b0,15'h0000, 1'b0,16'h0000, 1'b1,1'b0,15'h1234, 15'h0000,16'h0000,16'h7FFF,1'b1,1'b0},
    '{1'b0,1'b0, 1'b0,15'h0000, 1'b0,16'h0000, 1'b0,1'b0,15'h0000, 15'h0000,16'h0000,16'h7FFF,1'b0,1'b0},
    '{1'b1,1'b1, 1'b0,15'h0000, 1'b0,16'h0000, 1'b0,1'b0,15'h0000, 15'h0000,16'h0000,16'h7FFF,1'b0,1'b1},
    '{1'b0,1'b0, 1'b0,15'h0000, 1'b0,16'h0000, 1'b1,1'b1,15'h1555, 15'h0001,16'h0001,16'h9555,1'b0,1'b1},
    '{1'b0,1'b0, 1'b1,15'h0100, 1'b1,16'hFFFF, 1'b1,1'b0,15'h0ABC, 15'h0100,16'hFFFF,16'h0ABC,1'b0,1'b1},
    '{1'b1,1'b0, 1'b0,15'h0000, 1'b1,16'h0005, 1'b1,1'b1,15'h7777, 15'h0101,16'h0005,16'hF777,1'b0,1'b0},
    '{1'b0,1'b0, 1'b0,15'h0000, 1'b0,16'h0000, 1'b1,1'b0,15'h2222, 15'h0102,16'h0006,16'h0101,1'b0,1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0, cfg_ext_en = 1'b0;
  logic          addr_wr = 1'b0, cnt_wr = 1'b0, seq_go = 1'b0, seq_dir = 1'b0;
  logic [AW-1:0] addr_wdata = '0, dev_addr = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [AW:0]   xfer_q;
  logic          cnt_zero_pulse, ext_en_q;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dchan_addr_engine u_dchan_addr_engine (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_ext_en(cfg_ext_en),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .seq_go(seq_go), .seq_dir(seq_dir),
    .dev_addr(dev_addr), .addr_q(addr_q), .cnt_q(cnt_q), .xfer_q(xfer_q),
    .cnt_zero_pulse(cnt_zero_pulse), .ext_en_q(ext_en_q)
  );

  task automatic check(input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_load = 1'b0; cfg_ext_en = 1'b0; addr_wr = 1'b0; cnt_wr = 1'b0;
    seq_go = 1'b0; seq_dir = 1'b0; addr_wdata = '0; cnt_wdata = '0; dev_addr = '0;
  endtask

  // Apply current inputs for one edge, then sample 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses;
    idle_inputs();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    // R1: reset state
    check("R1", "addr", 16'(addr_q), 16'h0);
    check("R1", "cnt", cnt_q, 16'h0);
    check("R1", "xfer", xfer_q, 16'h0);
    check("R1", "pulse", 16'(cnt_zero_pulse), 16'h0);
    check("R1", "mode", 16'(ext_en_q), 16'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      cfg_load = VECS[i].cl; cfg_ext_en = VECS[i].cv;
      addr_wr = VECS[i].aw; addr_wdata = VECS[i].ad;
      cnt_wr = VECS[i].cw; cnt_wdata = VECS[i].cd;
      seq_go = VECS[i].sq; seq_dir = VECS[i].dr; dev_addr = VECS[i].dv;
      step();
      check("R2/R8", "addr", 16'(addr_q), 16'(VECS[i].ea));
      check("R3/R9", "cnt", cnt_q, VECS[i].ec);
      check("R5/R6", "xfer", xfer_q, VECS[i].ex);
      check("R4", "pulse", 16'(cnt_zero_pulse), 16'(VECS[i].ep));
      check("R7", "mode", 16'(ext_en_q), 16'(VECS[i].ee));
    end

    // R10: idle cycles hold everything
    for (int k = 0; k < 3; k++) begin
      dev_addr = 15'h3333; seq_dir = 1'b1;
      step();
      check("R10", "addr hold", 16'(addr_q), 16'h0102);
      check("R10", "cnt hold", cnt_q, 16'h0006);
      check("R10", "xfer hold", xfer_q, 16'h0101);
      check("R4", "no pulse idle", 16'(cnt_zero_pulse), 16'h0);
    end

    // R4: long run from 0xFFF0, exactly one pulse on the 16th sequence
    cnt_wr = 1'b1; cnt_wdata = 16'hFFF0;
    step();
    pulses = 0;
    for (int k = 1; k <= 20; k++) begin
      seq_go = 1'b1;
      step();
      if (cnt_zero_pulse) pulses++;
      if (k == 16) check("R4", "pulse at wrap", 16'(cnt_zero_pulse), 16'h1);
    end
    check("R4", "pulse count", 16'(pulses), 16'h1);
    check("R3", "cnt after run", cnt_q, 16'h0004);
    check("R2", "addr after run", 16'(addr_q), 16'h0116);
    check("R5", "xfer last", xfer_q, 16'h0115);

    // R1: reset mid-operation clears everything
    cfg_load = 1'b1; cfg_ext_en = 1'b1;
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1", "addr after rst", 16'(addr_q), 16'h0);
    check("R1", "cnt after rst", cnt_q, 16'h0);
    check("R1", "xfer after rst", xfer_q, 16'h0);
    check("R1", "mode after rst", 16'(ext_en_q), 16'h0);

    finish_run();
  end
endmodule